// File: doc/BRIEF.md
# Load/Store Lane Steering Unit

This unit sits between the load/store stage of a 32-bit core and a single-cycle local memory bus. It moves byte, halfword and word transfers onto and off the bus byte lanes. The bit numbering is big-endian and reversed: bit 0 is the most significant bit, and lane 0 is the most significant byte lane. For a store, the unit copies the low byte or low halfword of the source onto every lane of the matching size and raises the byte enables of the addressed lanes. For a load, it selects the addressed lanes of the returned word, moves them to the low end of the result and fills the upper bits with zeros.

Every request is checked for alignment. A word must have both address bits 30 and 31 clear. A halfword must have bit 31 clear. A byte access is always aligned. A misaligned request never reaches the bus. Instead, the unit raises an exception pulse and stores the full faulting address and the direction of the access.

Top module: `lsu_lane_steer`

## Requirements
- R1: The size code on `req_size` is 00 for byte, 01 for halfword and 10 for word. Code 11 behaves exactly like a word.
- R2: An aligned byte store drives source bits 24..31 on all four lanes. It raises only the enable bit whose index equals the address offset (address bits 30..31, read as a number 0..3, with `bus_be` bit 0 being lane 0).
- R3: An aligned halfword store drives source bits 16..31 on both halves of the bus. Offset 0 enables lanes 0 and 1. Offset 2 enables lanes 2 and 3.
- R4: An aligned word store drives the source word unchanged and enables all four lanes.
- R5: A byte load returns lane `offset` of the bus read data in result bits 24..31, with bits 0..23 zero.
- R6: A halfword load returns lanes 0..1 (offset 0) or lanes 2..3 (offset 2) in result bits 16..31, with bits 0..15 zero. A word load returns the read data unchanged.
- R7: A word access is misaligned when address bit 30 or bit 31 is set. A halfword access is misaligned when bit 31 is set. A byte access is never misaligned.
- R8: While a valid request is misaligned, `bus_as` and `bus_write` stay low, `bus_be` is all zero, and no load result is flagged in the next cycle.
- R9: In the cycle after a misaligned request, `exc_unaligned` is high for exactly one cycle. `exc_addr` then holds the full request address and `exc_store` holds its direction. Both keep their values until the next misaligned request.
- R10: `bus_as`, `bus_write`, `bus_addr`, `bus_wdata` and `bus_be` follow the request in the same cycle. `ld_valid` and `ld_data` appear in the cycle after an aligned load, and are steered from `bus_rdata` in that cycle.
- R11: After reset, `ld_valid`, `exc_unaligned` and `exc_store` are 0 and `exc_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents an access this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Byte address, bit 0 most significant |
| req_wdata | input | 32 | Store source register |
| bus_rdata | input | 32 | Read data returned by memory in the response cycle |
| bus_as | output | 1 | Address strobe, aligned requests only |
| bus_write | output | 1 | Write strobe |
| bus_addr | output | 32 | Address presented to memory |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_be | output | 4 | Byte enables, bit 0 = lane 0 (most significant) |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Right-justified, zero-filled load result |
| exc_unaligned | output | 1 | One-cycle misalignment exception pulse |
| exc_store | output | 1 | Direction of the last faulting access |
| exc_addr | output | 32 | Address of the last faulting access |

## Verification
The bench tries every size code, including the reserved one, at every address offset and in both directions. It repeats this sweep over several data patterns whose bytes all differ, so a wrong lane choice or a wrong replication shows up as a wrong byte value and cannot pass by chance. Misaligned cases are mixed with aligned ones. This shows that a fault suppresses the bus strobes, that the stored fault address survives the aligned accesses that follow, and that only the next fault overwrites it. Varying the upper address bits between patterns checks that the whole address is stored, not just the offset.

// File: rtl/lsu_steer_pkg.sv
package lsu_steer_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } lss_size_e;

   // Reserved code is folded onto a full-width transfer (R1)
   function automatic lss_size_e lss_norm_size(input logic [1:0] code);
      lss_size_e s;
      case (code)
         2'b00:   s = SZ_BYTE;
         2'b01:   s = SZ_HALF;
         default: s = SZ_WORD;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
   import lsu_steer_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  lss_size_e           size,
   input  logic [OFF_W-1:0]    offset,
   output logic                misaligned
);

   // R7: full-width needs offset zero, half needs even offset, byte is free
   always_comb begin
      case (size)
         SZ_BYTE: misaligned = 1'b0;
         SZ_HALF: misaligned = offset[0];
         default: misaligned = (offset != '0);
      endcase
   end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_steer_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 4,
   localparam int DATA_W   = LANE_W * NUM_LANES,
   localparam int OFF_W    = $clog2(NUM_LANES)
) (
   input  lss_size_e              size,
   input  logic [OFF_W-1:0]       offset,
   input  logic                   enable,
   input  logic [0:DATA_W-1]      src,
   output logic [0:DATA_W-1]      wdata,
   output logic [0:NUM_LANES-1]   be
);

   localparam int LSB_LANE = NUM_LANES - 1;

   logic [0:NUM_LANES-1] be_raw;

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      localparam int PAIR_POS = k % 2;
      localparam int PAIR_IDX = k / 2;
      logic [LANE_W-1:0] lane_byte, lane_half, lane_word;
      logic              en_byte, en_half;

      // R2: low source byte copied to every lane
      assign lane_byte = src[LSB_LANE*LANE_W +: LANE_W];
      // R3: low source halfword copied to every lane pair
      assign lane_half = src[(NUM_LANES-2+PAIR_POS)*LANE_W +: LANE_W];
      // R4: straight through
      assign lane_word = src[k*LANE_W +: LANE_W];

      assign en_byte = (offset == OFF_W'(k));
      assign en_half = ((offset >> 1) == OFF_W'(PAIR_IDX));

      always_comb begin
         case (size)
            SZ_BYTE: begin
               wdata[k*LANE_W +: LANE_W] = lane_byte;
               be_raw[k]                 = en_byte;
            end
            SZ_HALF: begin
               wdata[k*LANE_W +: LANE_W] = lane_half;
               be_raw[k]                 = en_half;
            end
            default: begin
               wdata[k*LANE_W +: LANE_W] = lane_word;
               be_raw[k]                 = 1'b1;
            end
         endcase
      end
   end

   assign be = enable ? be_raw : '0;

endmodule

// File: rtl/lsu_load_steer.sv
module lsu_load_steer
   import lsu_steer_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 4,
   localparam int DATA_W   = LANE_W * NUM_LANES,
   localparam int OFF_W    = $clog2(NUM_LANES),
   localparam int HALF_W   = 2 * LANE_W
) (
   input  lss_size_e              size,
   input  logic [OFF_W-1:0]       offset,
   input  logic [0:DATA_W-1]      rdata,
   output logic [0:DATA_W-1]      result
);

   logic [LANE_W-1:0] pick_byte;
   logic [HALF_W-1:0] pick_half;

   // R5: select the addressed lane
   always_comb begin
      pick_byte = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (offset == OFF_W'(i)) pick_byte = rdata[i*LANE_W +: LANE_W];
      end
   end

   // R6: select the addressed lane pair
   always_comb begin
      pick_half = '0;
      for (int j = 0; j < NUM_LANES / 2; j++) begin
         if ((offset >> 1) == OFF_W'(j)) pick_half = rdata[j*HALF_W +: HALF_W];
      end
   end

   // Right-justify with zero fill
   always_comb begin
      case (size)
         SZ_BYTE: result = {{(DATA_W-LANE_W){1'b0}}, pick_byte};
         SZ_HALF: result = {{(DATA_W-HALF_W){1'b0}}, pick_half};
         default: result = rdata;
      endcase
   end

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
   import lsu_steer_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LANE_W    = 8,
   parameter int NUM_LANES = 4,
   parameter bit LOAD_PIPE = 1'b0,
   localparam int DATA_W   = LANE_W * NUM_LANES,
   localparam int OFF_W    = $clog2(NUM_LANES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [1:0]            req_size,
   input  logic [0:ADDR_W-1]     req_addr,
   input  logic [0:DATA_W-1]     req_wdata,
   input  logic [0:DATA_W-1]     bus_rdata,
   output logic                  bus_as,
   output logic                  bus_write,
   output logic [0:ADDR_W-1]     bus_addr,
   output logic [0:DATA_W-1]     bus_wdata,
   output logic [0:NUM_LANES-1]  bus_be,
   output logic                  ld_valid,
   output logic [0:DATA_W-1]     ld_data,
   output logic                  exc_unaligned,
   output logic                  exc_store,
   output logic [0:ADDR_W-1]     exc_addr
);

   // Elaboration-time parameter checks
   if (LANE_W < 1) begin : g_bad_lane
      $error("lsu_lane_steer: LANE_W must be positive");
   end
   if (NUM_LANES < 2 || (NUM_LANES & (NUM_LANES - 1)) != 0) begin : g_bad_lanes
      $error("lsu_lane_steer: NUM_LANES must be a power of two >= 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("lsu_lane_steer: ADDR_W too narrow for the lane offset");
   end

   lss_size_e          size_n;
   logic [OFF_W-1:0]   req_off;
   logic               misaligned;
   logic               go;

   assign size_n  = lss_norm_size(req_size);
   assign req_off = req_addr[ADDR_W-OFF_W +: OFF_W];

   lsu_align_check #(.OFF_W(OFF_W)) u_align (
      .size       (size_n),
      .offset     (req_off),
      .misaligned (misaligned)
   );

   assign go = req_valid & ~misaligned;

   // Request path, same cycle (R10)
   assign bus_as    = go;
   assign bus_write = go & req_write;
   assign bus_addr  = req_addr;

   lsu_store_steer #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_store (
      .size   (size_n),
      .offset (req_off),
      .enable (go),
      .src    (req_wdata),
      .wdata  (bus_wdata),
      .be     (bus_be)
   );

   // Read context held for the response cycle
   lss_size_e          rd_size_q;
   logic [OFF_W-1:0]   rd_off_q;
   logic               rd_pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_size_q <= SZ_WORD;
         rd_off_q  <= '0;
         rd_pend_q <= 1'b0;
      end else begin
         rd_pend_q <= go & ~req_write;
         if (go & ~req_write) begin
            rd_size_q <= size_n;
            rd_off_q  <= req_off;
         end
      end
   end

   logic [0:DATA_W-1] steered;

   lsu_load_steer #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_load (
      .size   (rd_size_q),
      .offset (rd_off_q),
      .rdata  (bus_rdata),
      .result (steered)
   );

   if (LOAD_PIPE) begin : g_load_reg
      logic              ld_valid_q;
      logic [0:DATA_W-1] ld_data_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ld_valid_q <= 1'b0;
            ld_data_q  <= '0;
         end else begin
            ld_valid_q <= rd_pend_q;
            if (rd_pend_q) ld_data_q <= steered;
         end
      end
      assign ld_valid = ld_valid_q;
      assign ld_data  = ld_data_q;
   end else begin : g_load_comb
      assign ld_valid = rd_pend_q;
      assign ld_data  = steered;

      // R10: aligned load gives a result flag one cycle later
      a_r10_load_next: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_as && !bus_write) |=> ld_valid)
         else $error("a_r10_load_next");
   end

   // Misalignment exception capture (R9, R11)
   logic              exc_q;
   logic              exc_store_q;
   logic [0:ADDR_W-1] exc_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_q       <= 1'b0;
         exc_store_q <= 1'b0;
         exc_addr_q  <= '0;
      end else begin
         exc_q <= req_valid & misaligned;
         if (req_valid & misaligned) begin
            exc_store_q <= req_write;
            exc_addr_q  <= req_addr;
         end
      end
   end

   assign exc_unaligned = exc_q;
   assign exc_store     = exc_store_q;
   assign exc_addr      = exc_addr_q;

   // R7/R8: a word with low bits set never reaches the bus
   a_r8_word_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size[1] && req_addr[ADDR_W-OFF_W +: OFF_W] != '0)
         |-> (!bus_as && !bus_write && bus_be == '0))
      else $error("a_r8_word_blocked");

   // R9: a refused request raises the exception and captures the address
   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !bus_as) |=> (exc_unaligned && exc_addr == $past(req_addr)
                                  && exc_store == $past(req_write)))
      else $error("a_r9_capture");

   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !bus_as) |=> (!exc_unaligned && $stable(exc_addr)))
      else $error("a_r9_quiet");

   // R2: a byte access enables exactly one lane
   a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_as && req_size == 2'b00) |-> ($countones(bus_be) == 1))
      else $error("a_r2_one_lane");

   // R4: a word store is passed through on all lanes
   a_r4_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_write && req_size[1]) |-> (bus_wdata == req_wdata && (&bus_be)))
      else $error("a_r4_word_pass");

endmodule

// File: tb/lsu_lane_steer_bench.sv
module lsu_lane_steer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] bus_rdata = '0;
   logic        bus_as, bus_write;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_be;
   logic        ld_valid;
   logic [31:0] ld_data;
   logic        exc_unaligned, exc_store;
   logic [31:0] exc_addr;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_eaddr = '0;
   logic        m_estore = 1'b0;

   always #10 clk = ~clk;

   lsu_lane_steer u_lsu_lane_steer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
      .bus_as(bus_as), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_be(bus_be),
      .ld_valid(ld_valid), .ld_data(ld_data),
      .exc_unaligned(exc_unaligned), .exc_store(exc_store), .exc_addr(exc_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic wr, input logic [1:0] sz,
                         input logic [31:0] addr, input logic [31:0] sd,
                         input logic [31:0] rd);
      logic [1:0]  off;
      logic        bad;
      logic [3:0]  exp_be;
      logic [31:0] exp_wd, exp_ld;
      off = addr[1:0];
      // R1: 11 acts as word; R7: alignment rule
      case (sz)
         2'b00:   bad = 1'b0;
         2'b01:   bad = off[0];
         default: bad = (off != 2'b00);
      endcase
      case (sz)
         2'b00: begin exp_be = 4'b1000 >> off; exp_wd = {4{sd[7:0]}};
                      exp_ld = (rd >> (8 * (3 - off))) & 32'hFF; end
         2'b01: begin exp_be = off[1] ? 4'b0011 : 4'b1100; exp_wd = {2{sd[15:0]}};
                      exp_ld = off[1] ? {16'h0, rd[15:0]} : {16'h0, rd[31:16]}; end
         default: begin exp_be = 4'b1111; exp_wd = sd; exp_ld = rd; end
      endcase
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz;
      req_addr = addr; req_wdata = sd; bus_rdata = 32'hx;
      #1;
      if (bad) begin
         chk("R8 bus_as", {31'h0, bus_as}, 32'h0);
         chk("R8 bus_write", {31'h0, bus_write}, 32'h0);
         chk("R8 bus_be", {28'h0, bus_be}, 32'h0);
      end else begin
         chk("R10 bus_as", {31'h0, bus_as}, 32'h1);
         chk("R10 bus_write", {31'h0, bus_write}, {31'h0, wr});
         chk("R10 bus_addr", bus_addr, addr);
         if (sz == 2'b00)      chk("R2 byte be", {28'h0, bus_be}, {28'h0, exp_be});
         else if (sz == 2'b01) chk("R3 half be", {28'h0, bus_be}, {28'h0, exp_be});
         else                  chk("R4 word be", {28'h0, bus_be}, {28'h0, exp_be});
         if (wr) begin
            if (sz == 2'b00)      chk("R2 byte wdata", bus_wdata, exp_wd);
            else if (sz == 2'b01) chk("R3 half wdata", bus_wdata, exp_wd);
            else                  chk("R4 word wdata", bus_wdata, exp_wd);
         end
      end
      @(negedge clk);
      req_valid = 1'b0; bus_rdata = rd;
      #1;
      if (bad) begin
         m_eaddr = addr; m_estore = wr;
      end
      chk("R9 exc pulse", {31'h0, exc_unaligned}, {31'h0, bad});
      chk("R9 exc_addr", exc_addr, m_eaddr);
      chk("R9 exc_store", {31'h0, exc_store}, {31'h0, m_estore});
      chk("R8 ld_valid", {31'h0, ld_valid}, {31'h0, (!bad && !wr)});
      if (!bad && !wr) begin
         if (sz == 2'b00) chk("R5 byte load", ld_data, exp_ld);
         else             chk("R6 load", ld_data, exp_ld);
      end
      @(negedge clk);
      #1;
      chk("R9 single pulse", {31'h0, exc_unaligned}, 32'h0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] sd_pat [3];
      logic [31:0] rd_pat [3];
      logic [31:0] base_pat [3];
      sd_pat[0] = 32'h11223344; sd_pat[1] = 32'hA5C3F00F; sd_pat[2] = 32'hDEADBEEF;
      rd_pat[0] = 32'h8192A3B4; rd_pat[1] = 32'h0FF05AA5; rd_pat[2] = 32'hC0DE1234;
      base_pat[0] = 32'h00001000; base_pat[1] = 32'hFFFFFFF0; base_pat[2] = 32'h5A5A5A50;
      repeat (3) @(negedge clk);
      #1;
      // R11: reset state
      chk("R11 ld_valid", {31'h0, ld_valid}, 32'h0);
      chk("R11 exc_unaligned", {31'h0, exc_unaligned}, 32'h0);
      chk("R11 exc_store", {31'h0, exc_store}, 32'h0);
      chk("R11 exc_addr", exc_addr, 32'h0);
      rst_n = 1'b1;
      for (int p = 0; p < 3; p++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 4; off++) begin
               for (int wr = 0; wr < 2; wr++) begin
                  run_op(wr[0], sz[1:0], base_pat[p] + 32'(off) + 32'(sz * 16),
                         sd_pat[p] ^ 32'(off * 32'h01010101),
                         rd_pat[p] + 32'(sz * 32'h00110000));
               end
            end
         end
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule